// File: doc/BRIEF.md
# ADC Conversion Command Queue Sequencer

This block runs analog-to-digital conversions from a table of 64 command words. The table holds two queues. Queue 1 always starts at entry 0. Queue 2 starts at an entry chosen by the `q2_base_i` pointer. On a trigger, a queue walks its entries in order. For each entry it sends the channel, reference select and sample time to an external converter through a start/done handshake. The 10-bit answer is stored in the result slot with the same index as the command.

Each command word has three optional behaviours: a pause bit that stops the queue after that entry until the next trigger, a reserved channel code that ends the queue, and a reference select. Queue 1 has priority over queue 2. A queue 1 trigger that arrives while queue 2 is converting waits until that conversion finishes, and queue 2 then carries on from where it stopped. Software reads any result through a combinational port in one of three 16-bit alignments.

Top module: `adc_queue_seq`

## Requirements
- R1: After reset, every command entry holds the end-of-queue code. Every result entry is 0. Both queues are inactive, not paused and not complete. No start strobe is issued.
- R2: A command word is laid out as bit 9 pause, bit 8 alternate reference, bits 7:6 sample time and bits 5:0 channel. Each conversion produces a one-cycle `conv_start_o` pulse that carries that entry's channel, reference bit and sample time.
- R3: Only one conversion is outstanding at a time. No new start is issued until `conv_done_i` arrives. A `conv_done_i` while no conversion is outstanding changes no result and starts nothing.
- R4: The converter value returned for command entry i is written to result entry i. Other result entries are left unchanged.
- R5: A trigger on `trig_i[0]` starts queue 1 at entry 0. A trigger on `trig_i[1]` starts queue 2 at entry `q2_base_i`.
- R6: Channel code 63 ends the active queue without a conversion. The queue's complete flag is set and `q_end_o` pulses for exactly one cycle.
- R7: Queue 1 ends, without converting, when its pointer reaches `q2_base_i`. Either queue ends after converting entry 63.
- R8: A set pause bit converts the entry and then leaves the queue paused. The next trigger resumes at the following entry. A trigger while the queue is running is ignored.
- R9: Queue 1 preempts queue 2 after the conversion in progress. Queue 2 resumes at its next entry once queue 1 ends.
- R10: `rd_fmt_i` selects the read view of result r. The encodings are: 0 gives {6'b0, r}; 1 gives {r, 6'b0}; 2 gives {~r[9], r[8:0], 6'b0}; 3 reads as 0.
- R11: `q_active_o` is high while a queue runs or is paused. Starting a queue clears its complete flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | Command table write enable |
| cmd_addr_i | input | 6 | Command table write index |
| cmd_wdata_i | input | 10 | Command word to write |
| q2_base_i | input | 6 | First entry of queue 2 |
| trig_i | input | 2 | Trigger pulses, bit 0 queue 1, bit 1 queue 2 |
| conv_start_o | output | 1 | Start strobe to the converter |
| conv_chan_o | output | 6 | Channel to convert |
| conv_alt_ref_o | output | 1 | Alternate reference select |
| conv_ist_o | output | 2 | Sample time code |
| conv_done_i | input | 1 | Conversion finished strobe |
| conv_data_i | input | 10 | Converted value, valid with done |
| rd_addr_i | input | 6 | Result read index |
| rd_fmt_i | input | 2 | Result read alignment |
| rd_data_o | output | 16 | Formatted result |
| q_active_o | output | 2 | Queue running or paused |
| q_paused_o | output | 2 | Queue waiting for trigger after a pause |
| q_complete_o | output | 2 | Queue reached its end |
| q_end_o | output | 2 | One-cycle end pulse |

## Verification
The bench preempts queue 2 in the middle of a conversion. A design that dropped or restarted queue 2 would show a different channel order in the converter log. It resumes a paused queue and then triggers it again while it runs. Restarting on that second trigger would repeat the first entry's conversion. It stops queue 1 at the queue 2 boundary and runs queue 2 into entry 63. An off-by-one here would convert one extra entry or touch the boundary slot's result. It also sends a stray done while idle, and reads results in all four views so that a missing top-bit inversion or a wrong shift shows up.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CHAN_W = 6;
  localparam int unsigned IST_W  = 2;

  typedef struct packed {
    logic              pause;
    logic              alt_ref;
    logic [IST_W-1:0]  ist;
    logic [CHAN_W-1:0] chan;
  } ccw_t;

  localparam int unsigned CCW_W = $bits(ccw_t);
  localparam logic [CHAN_W-1:0] CHAN_EOQ = '1;

  typedef enum logic [1:0] {
    FMT_RIGHT  = 2'd0,
    FMT_LEFT   = 2'd1,
    FMT_SIGNED = 2'd2,
    FMT_NONE   = 2'd3
  } rd_fmt_e;

  typedef enum logic [1:0] {
    Q_IDLE  = 2'd0,
    Q_RUN   = 2'd1,
    Q_PAUSE = 2'd2
  } qstate_e;

  typedef enum logic {
    S_PICK = 1'b0,
    S_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/reg_table.sv
module reg_table #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned W       = 10,
  parameter logic [W-1:0] RST_VAL = '0,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= RST_VAL;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R4
endmodule

// File: rtl/queue_track.sv
module queue_track
  import adc_seq_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic             step_i,
  input  logic             step_pause_i,
  input  logic             stop_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             run_o,
  output logic             active_o,
  output logic             paused_o,
  output logic             complete_o,
  output logic             end_o
);
  qstate_e          st_q;
  logic [IDX_W-1:0] ptr_q;
  logic             cmp_q, end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= Q_IDLE;
      ptr_q <= '0;
      cmp_q <= 1'b0;
      end_q <= 1'b0;
    end else begin
      end_q <= stop_i;
      if (stop_i) begin
        st_q  <= Q_IDLE;
        cmp_q <= 1'b1;
      end else if (step_i) begin
        ptr_q <= ptr_q + 1'b1;
        if (step_pause_i) st_q <= Q_PAUSE;
      end else if (trig_i) begin
        case (st_q)
          Q_IDLE: begin
            ptr_q <= base_i;
            st_q  <= Q_RUN;
            cmp_q <= 1'b0;
          end
          Q_PAUSE: st_q <= Q_RUN;
          default: ;  // running: trigger ignored
        endcase
      end
    end
  end

  assign ptr_o      = ptr_q;
  assign run_o      = (st_q == Q_RUN);
  assign active_o   = (st_q != Q_IDLE);
  assign paused_o   = (st_q == Q_PAUSE);
  assign complete_o = cmp_q;
  assign end_o      = end_q;

  AST_STOP_STEP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_i && step_i)); // R6
  AST_END_PULSE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> complete_o && !active_o); // R6
  AST_PAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o && !trig_i |=> paused_o && $stable(ptr_o)); // R8
  AST_START_ON_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(trig_i)); // R5
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned RES_W   = 10,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        run_i,
  input  logic [IDX_W-1:0]  ptr0_i,
  input  logic [IDX_W-1:0]  ptr1_i,
  input  logic [IDX_W-1:0]  q2_base_i,
  output logic [IDX_W-1:0]  ccw_addr_o,
  input  ccw_t              ccw_i,
  output logic [1:0]        step_o,
  output logic              step_pause_o,
  output logic [1:0]        stop_o,
  output logic              conv_start_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  output logic              conv_alt_ref_o,
  output logic [IST_W-1:0]  conv_ist_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i,
  output logic              res_we_o,
  output logic [IDX_W-1:0]  res_addr_o,
  output logic [RES_W-1:0]  res_data_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  seq_state_e        st_q;
  logic              cur_q_q, cur_pause_q, start_q;
  logic [IDX_W-1:0]  cur_ptr_q;
  logic [CHAN_W-1:0] chan_q;
  logic              ref_q;
  logic [IST_W-1:0]  ist_q;

  logic             pick_valid, pick_q, hit_end;
  logic [IDX_W-1:0] pick_ptr;

  // queue 1 wins whenever it is runnable
  assign pick_valid = |run_i;
  assign pick_q     = !run_i[0];
  assign pick_ptr   = pick_q ? ptr1_i : ptr0_i;
  assign ccw_addr_o = pick_ptr;
  assign hit_end    = (ccw_i.chan == CHAN_EOQ) || (!pick_q && pick_ptr == q2_base_i);

  always_comb begin
    step_o       = '0;
    stop_o       = '0;
    step_pause_o = cur_pause_q;
    res_we_o     = 1'b0;
    if (st_q == S_PICK) begin
      if (pick_valid && hit_end) stop_o[pick_q] = 1'b1;
    end else if (conv_done_i) begin
      res_we_o = 1'b1;
      if (cur_ptr_q == LAST) stop_o[cur_q_q] = 1'b1;
      else                   step_o[cur_q_q] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_PICK;
      cur_q_q     <= 1'b0;
      cur_pause_q <= 1'b0;
      cur_ptr_q   <= '0;
      start_q     <= 1'b0;
      chan_q      <= '0;
      ref_q       <= 1'b0;
      ist_q       <= '0;
    end else begin
      start_q <= 1'b0;
      case (st_q)
        S_PICK: if (pick_valid && !hit_end) begin
          start_q     <= 1'b1;
          chan_q      <= ccw_i.chan;
          ref_q       <= ccw_i.alt_ref;
          ist_q       <= ccw_i.ist;
          cur_q_q     <= pick_q;
          cur_ptr_q   <= pick_ptr;
          cur_pause_q <= ccw_i.pause;
          st_q        <= S_WAIT;
        end
        default: if (conv_done_i) st_q <= S_PICK;
      endcase
    end
  end

  assign conv_start_o   = start_q;
  assign conv_chan_o    = chan_q;
  assign conv_alt_ref_o = ref_q;
  assign conv_ist_o     = ist_q;
  assign res_addr_o     = cur_ptr_q;
  assign res_data_o     = conv_data_i;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R3
  AST_ONE_QUEUE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({step_o, stop_o})); // R9
  AST_START_FROM_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> run_i[cur_q_q]); // R5
  AST_NO_EOQ_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> conv_chan_o != CHAN_EOQ); // R6
endmodule

// File: rtl/result_view.sv
module result_view
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  parameter int unsigned OUT_W = 16
) (
  input  logic [RES_W-1:0] res_i,
  input  logic [1:0]       fmt_i,
  output logic [OUT_W-1:0] data_o
);
  localparam int unsigned PAD = OUT_W - RES_W;

  always_comb begin
    case (rd_fmt_e'(fmt_i))
      FMT_RIGHT:  data_o = {{PAD{1'b0}}, res_i};
      FMT_LEFT:   data_o = {res_i, {PAD{1'b0}}};
      FMT_SIGNED: data_o = {~res_i[RES_W-1], res_i[RES_W-2:0], {PAD{1'b0}}};
      default:    data_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_queue_seq.sv
module adc_queue_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned RES_W   = 10,
  parameter int unsigned OUT_W   = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [IDX_W-1:0]  cmd_addr_i,
  input  logic [CCW_W-1:0]  cmd_wdata_i,
  input  logic [IDX_W-1:0]  q2_base_i,
  input  logic [1:0]        trig_i,
  output logic              conv_start_o,
  output logic [CHAN_W-1:0] conv_chan_o,
  output logic              conv_alt_ref_o,
  output logic [IST_W-1:0]  conv_ist_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  input  logic [1:0]        rd_fmt_i,
  output logic [OUT_W-1:0]  rd_data_o,
  output logic [1:0]        q_active_o,
  output logic [1:0]        q_paused_o,
  output logic [1:0]        q_complete_o,
  output logic [1:0]        q_end_o
);
  localparam logic [CCW_W-1:0] CCW_RST = CCW_W'(CHAN_EOQ);

  logic [IDX_W-1:0] ccw_addr, res_addr;
  logic [CCW_W-1:0] ccw_raw;
  logic [RES_W-1:0] res_wdata, res_rdata;
  logic             res_we, step_pause;
  logic [1:0]       step, stop, run;
  logic [IDX_W-1:0] qptr [2];

  reg_table #(.ENTRIES(ENTRIES), .W(CCW_W), .RST_VAL(CCW_RST)) u_cmd_tab (
    .clk_i, .rst_ni,
    .we_i(cmd_we_i), .waddr_i(cmd_addr_i), .wdata_i(cmd_wdata_i),
    .raddr_i(ccw_addr), .rdata_o(ccw_raw)
  );

  for (genvar q = 0; q < 2; q++) begin : g_queue
    queue_track #(.IDX_W(IDX_W)) u_q (
      .clk_i, .rst_ni,
      .trig_i(trig_i[q]),
      .base_i((q == 0) ? '0 : q2_base_i),
      .step_i(step[q]), .step_pause_i(step_pause), .stop_i(stop[q]),
      .ptr_o(qptr[q]), .run_o(run[q]),
      .active_o(q_active_o[q]), .paused_o(q_paused_o[q]),
      .complete_o(q_complete_o[q]), .end_o(q_end_o[q])
    );
  end

  seq_ctrl #(.ENTRIES(ENTRIES), .RES_W(RES_W)) u_seq (
    .clk_i, .rst_ni,
    .run_i(run), .ptr0_i(qptr[0]), .ptr1_i(qptr[1]), .q2_base_i,
    .ccw_addr_o(ccw_addr), .ccw_i(ccw_t'(ccw_raw)),
    .step_o(step), .step_pause_o(step_pause), .stop_o(stop),
    .conv_start_o, .conv_chan_o, .conv_alt_ref_o, .conv_ist_o,
    .conv_done_i, .conv_data_i,
    .res_we_o(res_we), .res_addr_o(res_addr), .res_data_o(res_wdata)
  );

  reg_table #(.ENTRIES(ENTRIES), .W(RES_W), .RST_VAL('0)) u_res_tab (
    .clk_i, .rst_ni,
    .we_i(res_we), .waddr_i(res_addr), .wdata_i(res_wdata),
    .raddr_i(rd_addr_i), .rdata_o(res_rdata)
  );

  result_view #(.RES_W(RES_W), .OUT_W(OUT_W)) u_view (
    .res_i(res_rdata), .fmt_i(rd_fmt_i), .data_o(rd_data_o)
  );
endmodule

// File: tb/adc_queue_seq_tb_top.sv
module adc_queue_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5ns clk = ~clk;

  logic       cmd_we = 0;
  logic [5:0] cmd_addr = 0, q2_base = 0, rd_addr = 0;
  logic [9:0] cmd_wdata = 0;
  logic [1:0] trig = 0, rd_fmt = 0;
  logic       conv_start, conv_ref, conv_done;
  logic [5:0] conv_chan;
  logic [1:0] conv_ist;
  logic [9:0] conv_data;
  logic [15:0] rd_data;
  logic [1:0] q_active, q_paused, q_complete, q_end;

  logic       model_done = 0, spur_done = 0;
  logic [9:0] model_data = 0, spur_data = 0, pend = 0;
  assign conv_done = model_done | spur_done;
  assign conv_data = spur_done ? spur_data : model_data;

  adc_queue_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_we_i(cmd_we), .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .q2_base_i(q2_base), .trig_i(trig),
    .conv_start_o(conv_start), .conv_chan_o(conv_chan), .conv_alt_ref_o(conv_ref),
    .conv_ist_o(conv_ist), .conv_done_i(conv_done), .conv_data_i(conv_data),
    .rd_addr_i(rd_addr), .rd_fmt_i(rd_fmt), .rd_data_o(rd_data),
    .q_active_o(q_active), .q_paused_o(q_paused),
    .q_complete_o(q_complete), .q_end_o(q_end)
  );

  int total = 0, bad = 0;
  int lat = 3, cnt = 0, nstart = 0, overlap = 0, pulse_err = 0;
  bit busy = 0;
  int log_chan [512];
  int log_ist  [512];
  int log_ref  [512];
  int n_end [2];
  logic [1:0] prev_end = 0;

  function automatic logic [9:0] exp_res(input int ch, input int ist, input int r);
    return {r[0], ist[1:0], 1'b0, ch[5:0]};
  endfunction

  // converter model
  always @(posedge clk) begin
    model_done <= 1'b0;
    if (conv_start) begin
      if (busy) overlap = overlap + 1;
      busy = 1;
      cnt  = lat;
      log_chan[nstart] = int'(conv_chan);
      log_ist[nstart]  = int'(conv_ist);
      log_ref[nstart]  = int'(conv_ref);
      pend <= {conv_ref, conv_ist, 1'b0, conv_chan};
      nstart = nstart + 1;
    end else if (busy) begin
      if (cnt <= 1) begin
        model_done <= 1'b1;
        model_data <= pend;
        busy = 0;
      end else cnt = cnt - 1;
    end
  end

  // end pulse monitor
  always @(posedge clk) begin
    for (int q = 0; q < 2; q++) begin
      if (q_end[q]) begin
        n_end[q] = n_end[q] + 1;
        if (prev_end[q]) pulse_err = pulse_err + 1;
      end
    end
    prev_end <= q_end;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int p, input int r, input int ist, input int ch);
    @(negedge clk);
    cmd_we = 1; cmd_addr = 6'(idx);
    cmd_wdata = {p[0], r[0], ist[1:0], ch[5:0]};
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic pulse_trig(input int q);
    @(negedge clk); trig[q] = 1'b1;
    @(negedge clk); trig = '0;
  endtask

  task automatic wait_cmp(input int q);
    int t = 0;
    while (!q_complete[q] && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_starts(input int n);
    int t = 0;
    while (nstart < n && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic chk_rd(input int idx, input int fmt, input int exp, input string req);
    rd_addr = 6'(idx); rd_fmt = 2'(fmt); #1;
    chk(rd_data == 16'(exp), req, int'(rd_data), exp);
  endtask

  task automatic t_reset;
    chk(q_active == 0 && q_paused == 0 && q_complete == 0, "R1 status", int'({q_active, q_paused, q_complete}), 0);
    chk_rd(5, 0, 0, "R1 result");
    chk(nstart == 0, "R1 no start", nstart, 0);
    pulse_trig(0);
    wait_cmp(0);
    @(negedge clk);
    chk(nstart == 0, "R6 eoq no conversion", nstart, 0);
    chk(q_complete[0] && !q_active[0], "R6 complete", int'(q_complete), 1);
    chk(n_end[0] == 1, "R6 end pulse count", n_end[0], 1);
  endtask

  task automatic t_basic;
    int n0;
    q2_base = 20;
    wr(0, 0, 1, 2, 5); wr(1, 0, 0, 1, 6); wr(2, 0, 1, 0, 7); wr(3, 0, 0, 3, 8);
    n0 = nstart;
    pulse_trig(0);
    chk(q_active[0] && !q_complete[0], "R11 active, complete cleared", int'({q_active[0], q_complete[0]}), 2);
    wait_cmp(0);
    chk(nstart - n0 == 4, "R5 queue1 count", nstart - n0, 4);
    chk(log_chan[n0] == 5 && log_chan[n0+3] == 8, "R5 queue1 order", log_chan[n0+3], 8);
    chk(log_ist[n0] == 2 && log_ref[n0] == 1, "R2 start fields", log_ist[n0]*2 + log_ref[n0], 5);
    chk_rd(0, 0, exp_res(5, 2, 1), "R4 result 0");
    chk_rd(3, 0, exp_res(8, 3, 0), "R4 result 3");
    wr(20, 0, 0, 0, 3); wr(21, 0, 1, 1, 9);
    n0 = nstart;
    pulse_trig(1);
    wait_cmp(1);
    chk(nstart - n0 == 2 && log_chan[n0] == 3, "R5 queue2 base", log_chan[n0], 3);
    chk_rd(21, 0, exp_res(9, 1, 1), "R4 result 21");
    chk_rd(22, 0, 0, "R4 untouched");
  endtask

  task automatic t_bounds;
    int n0;
    q2_base = 10;
    for (int i = 4; i <= 10; i++) wr(i, 0, 0, 0, 10 + i);
    n0 = nstart;
    pulse_trig(0);
    wait_cmp(0);
    chk(nstart - n0 == 10, "R7 stop at queue2 base", nstart - n0, 10);
    chk_rd(10, 0, 0, "R7 base slot untouched");
    q2_base = 62;
    wr(62, 0, 0, 0, 1); wr(63, 0, 0, 0, 2);
    n0 = nstart;
    pulse_trig(1);
    wait_cmp(1);
    chk(nstart - n0 == 2, "R7 stop after 63", nstart - n0, 2);
    chk_rd(63, 0, exp_res(2, 0, 0), "R7 entry 63 result");
  endtask

  task automatic t_pause;
    int n0, t;
    q2_base = 40; lat = 10;
    wr(40, 1, 0, 0, 11); wr(41, 0, 0, 0, 12);
    n0 = nstart;
    pulse_trig(1);
    t = 0;
    while (!q_paused[1] && t < 3000) begin @(negedge clk); t++; end
    chk(nstart - n0 == 1 && q_active[1], "R8 paused after entry", nstart - n0, 1);
    repeat (5) @(negedge clk);
    chk(q_paused[1] && nstart - n0 == 1, "R8 holds without trigger", nstart - n0, 1);
    pulse_trig(1);
    wait_starts(n0 + 2);
    pulse_trig(1);
    wait_cmp(1);
    chk(nstart - n0 == 2, "R8 running trigger ignored", nstart - n0, 2);
    chk(log_chan[n0+1] == 12, "R8 resume next entry", log_chan[n0+1], 12);
    lat = 3;
  endtask

  task automatic t_prio;
    int n0;
    int exp_ch [6] = '{30, 31, 5, 6, 32, 33};
    lat = 6; q2_base = 30;
    for (int i = 30; i <= 33; i++) wr(i, 0, 0, 0, i);
    wr(2, 0, 0, 0, 63);
    n0 = nstart;
    pulse_trig(1);
    wait_starts(n0 + 2);
    pulse_trig(0);
    wait_cmp(1);
    chk(nstart - n0 == 6, "R9 total conversions", nstart - n0, 6);
    for (int i = 0; i < 6; i++)
      chk(log_chan[n0+i] == exp_ch[i], "R9 preempt order", log_chan[n0+i], exp_ch[i]);
    chk(q_complete == 2'b11, "R9 both complete", int'(q_complete), 3);
    lat = 3;
  endtask

  task automatic t_formats;
    logic [9:0] r;
    for (int k = 0; k < 2; k++) begin
      r = (k == 0) ? exp_res(5, 2, 1) : exp_res(6, 1, 0);
      chk_rd(k, 0, int'({6'b0, r}), "R10 right");
      chk_rd(k, 1, int'({r, 6'b0}), "R10 left");
      chk_rd(k, 2, int'({~r[9], r[8:0], 6'b0}), "R10 signed");
      chk_rd(k, 3, 0, "R10 unused code");
    end
  endtask

  task automatic t_spur;
    int n0;
    n0 = nstart;
    @(negedge clk); spur_data = 10'h3FF; spur_done = 1;
    @(negedge clk); spur_done = 0;
    repeat (3) @(negedge clk);
    chk_rd(33, 0, exp_res(33, 0, 0), "R3 stray done last slot");
    chk_rd(0, 0, exp_res(5, 2, 1), "R3 stray done slot 0");
    chk(nstart == n0 && q_active == 0, "R3 stray done no start", nstart - n0, 0);
    chk(overlap == 0, "R3 single outstanding", overlap, 0);
    chk(pulse_err == 0, "R6 end pulse width", pulse_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bounds();
    t_pause();
    t_prio();
    t_formats();
    t_spur();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule